// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer on a simple word-addressed register port. A programmable clock divider feeds a down-counter. The counter is loaded from a coarse 12-bit reload field that is scaled by a fixed power of two. Software must keep restarting the counter by writing one exact value to the restart location. If it fails to, the counter runs out. The block then records the event in a sticky status flag and, depending on the mode bits, drives a reset pulse of programmable length, a level interrupt, or both.

Writes to the two control locations are protected. Each written word must carry a fixed key pattern in its upper bits, or the whole write is discarded. A stray store therefore cannot disable the timer or change its period.

The scale factor (default 4096) and the four divider ratios (defaults 8, 64, 512 and 4096) are parameters. A system can shorten them for fast runs without changing the register layout.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the mode word (address 0x0) reads 0 and the counter-control word (address 0x4) reads 0x3FFF, which is reload 0xFFF with divider select 3. The status word (address 0xC) reads 0, and both the reset and interrupt outputs are low.
- R2: A write to address 0x0 is accepted only when bits [23:12] equal 0xABC; otherwise nothing changes. When accepted, the written bits set the mode: bit 0 runs the timer, bit 1 enables the reset output, bit 2 enables the interrupt, and bits [5:4] give the pulse-length code. The mode word reads back with these bits in the same places and all other bits 0.
- R3: A write to address 0x4 is accepted only when bits [23:14] equal 0x248, which is the pattern 0x00920000; otherwise nothing changes. Bits [1:0] select the divider and bits [13:2] hold the reload value. The word reads back as bits [13:0].
- R4: Divider select 0, 1, 2 and 3 make the counter step once every 2^PRE0_LOG2, 2^PRE1_LOG2, 2^PRE2_LOG2 and 2^PRE3_LOG2 clock cycles respectively.
- R5: The counter is loaded by a run-bit rise from 0 to 1 or by a valid restart. After a load, the timeout occurs exactly reload × 2^SCALE_LOG2 × divider clock cycles later. A reload of 0 times out on the first divider step.
- R6: Writing exactly 0x00001999 to address 0x8 reloads the counter and the divider and clears the timeout. Any other value written there has no effect.
- R7: Status bit 0 is set by a timeout and stays set. It is cleared by a valid restart, or by a key-valid mode write with bit 0 = 0. While the run bit is 0, the counter does not advance and no timeout occurs.
- R8: When the reset output is enabled, each timeout starts a high pulse of 2^(code+1) clock cycles (code 3 gives 16). The pulse begins in the cycle right after the timeout edge and fires only once per timeout.
- R9: When the interrupt is enabled, the interrupt output goes high with the timeout and stays high until a valid restart or a disable. When the interrupt is disabled, the output stays low.
- R10: When a valid restart lands on the same clock edge as a timeout would, the restart wins: no timeout is recorded and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_rst_o | output | 1 | Timeout reset pulse |
| wdt_irq_o | output | 1 | Timeout interrupt, level |

## Verification
A software restart and a counter expiry can fall on the same clock edge. The bench provokes this by counting cycles from a known restart and placing a second restart so that its write edge lands on the exact edge where the period runs out. It then judges that the interrupt and status stay low on that edge and that the next expiry comes one full period later. Both of these would be wrong if the expiry were allowed to win or to merge with the reload.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int WORD_W   = 32;
  localparam int RELOAD_W = 12;

  localparam logic [11:0]       MODE_KEY  = 12'hABC;
  localparam logic [9:0]        CCTL_KEY  = 10'h248;
  localparam logic [WORD_W-1:0] KICK_WORD = 32'h0000_1999;

  typedef struct packed {
    logic [1:0] plen;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } mode_t;

  typedef struct packed {
    logic [RELOAD_W-1:0] reload;
    logic [1:0]          psel;
  } cctl_t;

  // pulse length in cycles for a length code: 2, 4, 8, 16
  function automatic logic [4:0] pulse_len(input logic [1:0] code);
    return 5'd2 << code;
  endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              expired,
  output mode_t             mode_q,
  output cctl_t             cctl_q,
  output logic              restart_hit,
  output logic              enable_rise,
  output logic              disable_hit,
  output logic [WORD_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_CCTL = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4'hC);

  logic wr, mode_key_ok, cctl_key_ok, mode_wr, cctl_wr;

  assign wr          = valid && write;
  assign mode_key_ok = (wdata[23:12] == MODE_KEY);
  assign cctl_key_ok = (wdata[23:14] == CCTL_KEY);
  assign mode_wr     = wr && (addr == A_MODE) && mode_key_ok;
  assign cctl_wr     = wr && (addr == A_CCTL) && cctl_key_ok;
  assign restart_hit = wr && (addr == A_KICK) && (wdata == KICK_WORD);
  assign enable_rise = mode_wr && wdata[0] && !mode_q.run;
  assign disable_hit = mode_wr && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q.plen   <= wdata[5:4];
      mode_q.irq_en <= wdata[2];
      mode_q.rst_en <= wdata[1];
      mode_q.run    <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cctl_q.reload <= '1;
      cctl_q.psel   <= 2'd3;
    end else if (cctl_wr) begin
      cctl_q.reload <= wdata[13:2];
      cctl_q.psel   <= wdata[1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MODE: rdata = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.run};
      A_CCTL: rdata = {18'd0, cctl_q.reload, cctl_q.psel};
      A_STAT: rdata = {31'd0, expired};
      default: rdata = '0;
    endcase
  end

  // a mode write with a wrong key leaves the mode untouched
  p_bad_mode_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_MODE && !mode_key_ok) |=> $stable(mode_q));

  // a counter-control write with a wrong key leaves the field untouched
  p_bad_cctl_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CCTL && !cctl_key_ok) |=> $stable(cctl_q));

endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
  parameter int PRE0_LOG2 = 3,
  parameter int PRE1_LOG2 = 6,
  parameter int PRE2_LOG2 = 9,
  parameter int PRE3_LOG2 = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] psel,
  output logic       tick
);

  localparam int L01    = (PRE0_LOG2 > PRE1_LOG2) ? PRE0_LOG2 : PRE1_LOG2;
  localparam int L23    = (PRE2_LOG2 > PRE3_LOG2) ? PRE2_LOG2 : PRE3_LOG2;
  localparam int MAXLOG = (L01 > L23) ? L01 : L23;
  localparam int PW     = MAXLOG + 1;

  function automatic logic [PW-1:0] last_of(input logic [1:0] s);
    logic [63:0] d;
    unique case (s)
      2'd0: d = 64'd1 << PRE0_LOG2;
      2'd1: d = 64'd1 << PRE1_LOG2;
      2'd2: d = 64'd1 << PRE2_LOG2;
      default: d = 64'd1 << PRE3_LOG2;
    endcase
    return PW'(d - 64'd1);
  endfunction

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;

  assign last = last_of(psel);
  // >= so a change of select to a shorter ratio cannot make the counter wrap
  assign tick = run && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || !run)  cnt_q <= '0;
    else if (tick)         cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // a step only comes out while running
  p_tick_only_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown
  import kwd_pkg::*;
#(
  parameter int SCALE_LOG2 = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                load,
  input  logic                clear,
  input  logic                tick,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expired,
  output logic                fire
);

  localparam int CNT_W = RELOAD_W + SCALE_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             expired_q;

  assign load_val = CNT_W'(reload) << SCALE_LOG2;
  // a load on the same edge suppresses the expiry: restart wins
  assign fire     = run && tick && !load && !expired_q && (cnt_q <= CNT_W'(1));
  assign expired  = expired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt_q <= '0;
    else if (load)                         cnt_q <= load_val;
    else if (run && tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     expired_q <= 1'b0;
    else if (clear) expired_q <= 1'b0;
    else if (fire)  expired_q <= 1'b1;
  end

  // expiry only arises from a running counter at its last step
  p_expire_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_q) |-> ($past(cnt_q) <= CNT_W'(1)) && $past(run));

  // a restart or disable leaves the flag clear
  p_clear_drops_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired_q);

  // the count holds while stopped
  p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       rst_en,
  input  logic [1:0] plen,
  output logic       pulse_o
);

  logic [4:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left_q <= '0;
    else if (fire && rst_en)   left_q <= pulse_len(plen);
    else if (left_q != '0)     left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  // checker: length of the current high run
  logic [5:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run_len <= '0;
    else if (!pulse_o)                  run_len <= '0;
    else if (run_len != 6'h3F)          run_len <= run_len + 1'b1;
  end

  p_fire_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rst_en) |=> pulse_o);

  p_pulse_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (run_len < 6'd16));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int SCALE_LOG2 = 12,
  parameter int PRE0_LOG2  = 3,
  parameter int PRE1_LOG2  = 6,
  parameter int PRE2_LOG2  = 9,
  parameter int PRE3_LOG2  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);

  mode_t mode_q;
  cctl_t cctl_q;
  logic  restart_hit, enable_rise, disable_hit;
  logic  tick, expired, fire;
  logic  load_evt, clear_evt;

  assign load_evt  = restart_hit || enable_rise;
  assign clear_evt = restart_hit || disable_hit;

  kwd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .valid(bus_valid), .write(bus_write),
    .addr(bus_addr), .wdata(bus_wdata), .expired(expired),
    .mode_q(mode_q), .cctl_q(cctl_q), .restart_hit(restart_hit),
    .enable_rise(enable_rise), .disable_hit(disable_hit), .rdata(bus_rdata)
  );

  kwd_prescaler #(
    .PRE0_LOG2(PRE0_LOG2), .PRE1_LOG2(PRE1_LOG2),
    .PRE2_LOG2(PRE2_LOG2), .PRE3_LOG2(PRE3_LOG2)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .run(mode_q.run), .clr(load_evt),
    .psel(cctl_q.psel), .tick(tick)
  );

  kwd_countdown #(.SCALE_LOG2(SCALE_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(mode_q.run), .load(load_evt),
    .clear(clear_evt), .tick(tick), .reload(cctl_q.reload),
    .expired(expired), .fire(fire)
  );

  kwd_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rst_en(mode_q.rst_en),
    .plen(mode_q.plen), .pulse_o(wdt_rst_o)
  );

  assign wdt_irq_o = expired && mode_q.irq_en;

  // interrupt drops on the edge of a valid restart
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_hit |=> !wdt_irq_o);

endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;

  localparam int PERIOD = 10;
  localparam int SCALE  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o, wdt_irq_o;

  keyed_wdt #(
    .ADDR_W(4), .SCALE_LOG2(SCALE),
    .PRE0_LOG2(1), .PRE1_LOG2(2), .PRE2_LOG2(3), .PRE3_LOG2(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
  );

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad   = 0;

  typedef struct {
    int    due;
    int    sig;   // 0 = interrupt, 1 = reset pulse
    bit    val;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic int divider(input int sel);
    return 2 << sel;
  endfunction

  function automatic int period_of(input int reload, input int sel);
    int n;
    n = reload * (1 << SCALE);
    if (n == 0) n = 1;
    return n * divider(sel);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_at(input int due, input int sig, input bit val, input string tag);
    exp_t e;
    e.due = due; e.sig = sig; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares outputs at the falling edge after the due edge
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        chk(sb_q[i].tag, (sb_q[i].sig == 0) ? {31'd0, wdt_irq_o} : {31'd0, wdt_rst_o},
            {31'd0, sb_q[i].val});
        sb_q.delete(i);
      end
    end
  end

  // called at a falling edge; the write takes effect on edge cyc+1
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic logic [31:0] cctl_word(input int reload, input int sel);
    return 32'h0092_0000 | (32'(reload) << 2) | 32'(sel);
  endfunction

  localparam logic [31:0] OFF = 32'h00AB_C000;

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL [watchdog] actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int e, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(4'h0, rd); chk("R1 mode", rd, 32'h0);
    bus_rd(4'h4, rd); chk("R1 cctl", rd, 32'h3FFF);
    bus_rd(4'hC, rd); chk("R1 status", rd, 32'h0);
    chk("R1 outputs", {30'd0, wdt_rst_o, wdt_irq_o}, 32'h0);

    // R3 key check on counter control
    bus_wr(4'h4, 32'h0093_0000 | cctl_word(3, 1));
    bus_rd(4'h4, rd); chk("R3 bad key ignored", rd, 32'h3FFF);
    bus_wr(4'h4, cctl_word(3, 1));
    bus_rd(4'h4, rd); chk("R3 readback", rd, 32'h000D);

    // R2 key check on mode
    bus_wr(4'h0, 32'h00AB_D007);
    bus_rd(4'h0, rd); chk("R2 bad key ignored", rd, 32'h0);

    // R5 R9 timeout with interrupt
    bus_wr(4'h0, OFF | 32'h5);
    e = cyc; t = period_of(3, 1);
    bus_rd(4'h0, rd); chk("R2 readback", rd, 32'h5);
    expect_at(e + t - 1, 0, 1'b0, "R5 not yet");
    expect_at(e + t, 0, 1'b1, "R5 R9 expiry");
    expect_at(e + t + 10, 0, 1'b1, "R9 level held");
    wait_until(e + t + 2);
    bus_rd(4'hC, rd); chk("R7 sticky status", rd, 32'h1);
    wait_until(e + t + 12);

    // R6 wrong restart value ignored, right one clears
    bus_wr(4'h8, 32'h0000_1998);
    chk("R6 wrong kick ignored", {31'd0, wdt_irq_o}, 32'h1);
    bus_rd(4'hC, rd); chk("R6 wrong kick status", rd, 32'h1);
    bus_wr(4'h8, 32'h0000_1999);
    e = cyc;
    chk("R6 kick drops irq", {31'd0, wdt_irq_o}, 32'h0);
    bus_rd(4'hC, rd); chk("R6 kick clears status", rd, 32'h0);
    expect_at(e + t - 1, 0, 1'b0, "R6 reload not yet");
    expect_at(e + t, 0, 1'b1, "R6 reload expiry");
    wait_until(e + t + 2);

    // R10 restart on the same edge as the expiry
    bus_wr(4'h8, 32'h0000_1999);
    e = cyc;
    wait_until(e + t - 1);
    bus_wr(4'h8, 32'h0000_1999);
    chk("R10 restart wins irq", {31'd0, wdt_irq_o}, 32'h0);
    bus_rd(4'hC, rd); chk("R10 restart wins status", rd, 32'h0);
    e = cyc;
    expect_at(e + t - 1, 0, 1'b0, "R10 full period");
    expect_at(e + t, 0, 1'b1, "R10 next expiry");
    wait_until(e + t + 2);

    // R7 disable clears status
    bus_wr(4'h0, OFF | 32'h4);
    bus_rd(4'hC, rd); chk("R7 disable clears", rd, 32'h0);
    chk("R7 irq low off", {31'd0, wdt_irq_o}, 32'h0);

    // R4 each divider select
    for (int s = 0; s < 4; s++) begin
      int te, tp;
      bus_wr(4'h4, cctl_word(1, s));
      bus_wr(4'h0, OFF | 32'h5);
      te = cyc; tp = period_of(1, s);
      expect_at(te + tp - 1, 0, 1'b0, "R4 before step");
      expect_at(te + tp, 0, 1'b1, "R4 divider period");
      wait_until(te + tp + 2);
      bus_wr(4'h0, OFF | 32'h4);
    end

    // R5 reload zero expires on first step
    bus_wr(4'h4, cctl_word(0, 1));
    bus_wr(4'h0, OFF | 32'h5);
    e = cyc;
    expect_at(e + 3, 0, 1'b0, "R5 zero before");
    expect_at(e + 4, 0, 1'b1, "R5 zero reload");
    wait_until(e + 6);
    bus_wr(4'h0, OFF | 32'h4);

    // R7 counter frozen while disabled
    bus_wr(4'h4, cctl_word(2, 0));
    bus_wr(4'h0, OFF | 32'h5);
    e = cyc;
    wait_until(e + 5);
    bus_wr(4'h0, OFF | 32'h4);
    wait_until(e + 40);
    bus_rd(4'hC, rd); chk("R7 no expiry stopped", rd, 32'h0);
    bus_wr(4'h0, OFF | 32'h5);
    e = cyc; t = period_of(2, 0);
    expect_at(e + t - 1, 0, 1'b0, "R7 fresh load");
    expect_at(e + t, 0, 1'b1, "R7 expiry after rerun");
    wait_until(e + t + 2);
    bus_wr(4'h0, OFF | 32'h4);

    // R8 reset pulse, 16 cycles, interrupt disabled
    bus_wr(4'h4, cctl_word(1, 0));
    bus_wr(4'h0, OFF | 32'h33);
    e = cyc; t = period_of(1, 0);
    bus_rd(4'h0, rd); chk("R2 mode fields", rd, 32'h33);
    expect_at(e + t - 1, 1, 1'b0, "R8 before pulse");
    expect_at(e + t, 1, 1'b1, "R8 pulse start");
    expect_at(e + t + 15, 1, 1'b1, "R8 pulse last");
    expect_at(e + t + 16, 1, 1'b0, "R8 pulse end");
    expect_at(e + t + 40, 1, 1'b0, "R8 once per timeout");
    expect_at(e + t + 1, 0, 1'b0, "R9 irq disabled");
    wait_until(e + t + 42);
    bus_rd(4'hC, rd); chk("R8 status set", rd, 32'h1);

    // R8 shortest pulse after restart, code 0
    bus_wr(4'h0, OFF | 32'h03);
    bus_wr(4'h8, 32'h0000_1999);
    e = cyc;
    expect_at(e + t, 1, 1'b1, "R8 short start");
    expect_at(e + t + 1, 1, 1'b1, "R8 short second");
    expect_at(e + t + 2, 1, 1'b0, "R8 short end");
    wait_until(e + t + 4);

    wait (sb_q.size() == 0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule